// File: doc/BRIEF.md
# Cosine-Law Stereo Fade Processor

This block applies a level control to a stereo stream of 18-bit signed audio samples. An 8-bit gain counter picks a 17-bit coefficient from a table that is built at elaboration and follows a quarter-cosine law. Count 0 gives unity gain. Count 255 gives silence. The attenuation in decibels at count c is 20·log10(cos(π·c/510)). Each sample that arrives with the valid strobe is multiplied by the current coefficient, rounded back to 18 bits and saturated. The scaled pair appears one clock later.

A host writes commands through a small write port. With the select bit low, the write loads a 4-bit slow-ramp rate. With the select bit high, the write is a fade command. Single-step commands nudge the counter by one count at once. Ramp commands set a target count: full scale, mute or −12 dB. The counter then walks toward that target automatically. A fast ramp moves one count per stereo sample. A slow ramp moves one count per (rate+1) word-select ticks.

Top module: `cosfade_core`

## Requirements
- R1: While reset is high and on the first cycle after it, the gain count is 0, the output valid is low and both outputs are 0. The slow rate is 0 and no ramp is active.
- R2: The coefficient for count c is k(c) = floor(cos(π·c/510)·65536 + 0.5). When `smp_valid` is high at a clock edge, each output on the next cycle equals floor((x·k + 32768) / 65536) saturated to the 18-bit signed range. Here x is that channel's input and k uses the count held before the edge. `smp_out_valid` is high exactly on the cycles that follow a valid sample. The outputs hold between valid samples.
- R3: Fade command 4'b0001 adds one to the count, saturating at 255. Command 4'b0010 subtracts one, saturating at 0. Both take effect on the next cycle and cancel any active ramp.
- R4: A fade command whose bits [3:2] are nonzero starts a ramp. The target depends on bits [3:2]: 01 gives count 0, 10 gives count 255 and 11 gives count 214. Bit 0 selects fast (1) or slow (0). Bit 1 is ignored. The slow tick divider restarts.
- R5: In a fast ramp the count moves one step toward the target on each valid sample and stops at the target. `ws_tick` has no effect on it.
- R6: In a slow ramp each `ws_tick` advances a divider. When the divider has reached the rate, the count steps toward the target and the divider clears, so one step happens every rate+1 ticks. `smp_valid` does not move the count.
- R7: A write with `cmd_sel` low loads `cmd_data` as the slow rate and leaves the count unchanged.
- R8: Fade commands 4'b0000 and 4'b0011 change nothing and leave an active ramp running.
- R9: In a cycle with any command write, no automatic ramp step is taken.
- R10: The gain count changes by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A stereo sample pair is present this cycle |
| smp_in_l | input | 18 | Left input sample, two's complement |
| smp_in_r | input | 18 | Right input sample, two's complement |
| ws_tick | input | 1 | One pulse per word-select period, clocks slow ramps |
| cmd_we | input | 1 | Command write strobe |
| cmd_sel | input | 1 | 0: rate register, 1: fade command |
| cmd_data | input | 4 | Command or rate value |
| smp_out_valid | output | 1 | Scaled pair valid |
| smp_out_l | output | 18 | Scaled left sample |
| smp_out_r | output | 18 | Scaled right sample |
| fade_count | output | 8 | Current gain count (0 unity, 255 mute) |

## Verification
The gain count leaves the block as `fade_count`, so a wrong target, a lost step or a stuck divider appears there on the very next clock. A wrong coefficient, rounding or count selection shows on the scaled samples one cycle after the valid strobe. The bench keeps a model of count, target, rate and divider and compares all outputs every cycle. Random command, tick and sample traffic runs alongside directed ramps through both saturation ends and the priority and no-op cases.

// File: rtl/cosfade_pkg.sv
`timescale 1ns/1ps
package cosfade_pkg;
    localparam int SMP_W     = 18;
    localparam int FC_W      = 8;
    localparam int COEF_W    = 17;
    localparam int RATE_W    = 4;
    localparam int CMD_W     = 4;
    localparam int CHANNELS  = 2;
    localparam int FC_MAX    = (1 << FC_W) - 1;
    localparam int COEF_FRAC = COEF_W - 1;
    localparam int PROD_W    = SMP_W + COEF_W + 1;
    localparam int FC_M12DB  = 214;

    typedef logic signed [SMP_W-1:0]  sample_t;
    typedef logic        [FC_W-1:0]   fc_t;
    typedef logic        [COEF_W-1:0] coef_t;
    typedef logic        [RATE_W-1:0] rate_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef enum logic [1:0] {OP_NONE, OP_ATTEN, OP_BOOST, OP_RAMP} fade_op_e;

    typedef struct packed {
        fade_op_e op;
        fc_t      target;
        logic     fast;
    } fade_cmd_t;

    function automatic fade_cmd_t decode_cmd(input logic [CMD_W-1:0] d);
        fade_cmd_t c;
        c.op     = OP_NONE;
        c.target = '0;
        c.fast   = d[0];
        unique case (d[3:2])
            2'b00: begin
                if (d[1:0] == 2'b01)      c.op = OP_ATTEN;
                else if (d[1:0] == 2'b10) c.op = OP_BOOST;
                else                      c.op = OP_NONE;
            end
            2'b01: begin c.op = OP_RAMP; c.target = '0; end
            2'b10: begin c.op = OP_RAMP; c.target = fc_t'(FC_MAX); end
            default: begin c.op = OP_RAMP; c.target = fc_t'(FC_M12DB); end
        endcase
        return c;
    endfunction

    function automatic sample_t scale_sample(input sample_t s, input coef_t k);
        prod_t p;
        prod_t hi;
        prod_t lo;
        hi = prod_t'((1 <<< (SMP_W - 1)) - 1);
        lo = prod_t'(-(1 <<< (SMP_W - 1)));
        p  = prod_t'(s) * prod_t'($signed({1'b0, k})) + prod_t'(1 <<< (COEF_FRAC - 1));
        p  = p >>> COEF_FRAC;
        if (p > hi)      p = hi;
        else if (p < lo) p = lo;
        return sample_t'(p);
    endfunction
endpackage

// File: rtl/cosfade_rom.sv
`timescale 1ns/1ps
module cosfade_rom
    import cosfade_pkg::*;
(
    input  fc_t   idx,
    output coef_t coef
);
    localparam int  ENTRIES = FC_MAX + 1;
    localparam real HALF_PI_STEP = 3.14159265358979 / (2.0 * FC_MAX);
    localparam real FULL_SCALE   = 2.0 ** COEF_FRAC;

    coef_t tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        localparam int VAL = $rtoi($cos(HALF_PI_STEP * g) * FULL_SCALE + 0.5);
        assign tbl[g] = coef_t'(VAL);
    end

    assign coef = tbl[idx];
endmodule

// File: rtl/cosfade_ctrl.sv
`timescale 1ns/1ps
module cosfade_ctrl
    import cosfade_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic             ws_tick,
    input  logic             cmd_we,
    input  logic             cmd_sel,
    input  logic [CMD_W-1:0] cmd_data,
    output fc_t              fc
);
    fc_t       target;
    logic      fast;
    logic      active;
    rate_t     rate;
    rate_t     div;
    fade_cmd_t cmd;
    logic      slow_hit;
    logic      fast_hit;
    logic      move;

    always_comb begin
        cmd      = decode_cmd(cmd_data);
        slow_hit = active && !fast && ws_tick && (div >= rate);
        fast_hit = active && fast && smp_valid;
        move     = (slow_hit || fast_hit) && (fc != target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fc     <= '0;
            target <= '0;
            fast   <= 1'b0;
            active <= 1'b0;
            rate   <= '0;
            div    <= '0;
        end else if (cmd_we) begin
            if (!cmd_sel) begin
                rate <= cmd_data[RATE_W-1:0];
            end else begin
                unique case (cmd.op)
                    OP_ATTEN: begin
                        if (fc != fc_t'(FC_MAX)) fc <= fc + fc_t'(1);
                        active <= 1'b0;
                    end
                    OP_BOOST: begin
                        if (fc != '0) fc <= fc - fc_t'(1);
                        active <= 1'b0;
                    end
                    OP_RAMP: begin
                        target <= cmd.target;
                        fast   <= cmd.fast;
                        active <= 1'b1;
                        div    <= '0;
                    end
                    default: ;
                endcase
            end
        end else begin
            if (active && !fast && ws_tick)
                div <= slow_hit ? '0 : div + rate_t'(1);
            if (move)
                fc <= (fc < target) ? fc + fc_t'(1) : fc - fc_t'(1);
        end
    end
endmodule

// File: rtl/cosfade_scale.sv
`timescale 1ns/1ps
module cosfade_scale
    import cosfade_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  sample_t din,
    input  coef_t   coef,
    output sample_t dout
);
    always_ff @(posedge clk) begin
        if (rst)     dout <= '0;
        else if (en) dout <= scale_sample(din, coef);
    end
endmodule

// File: rtl/cosfade_core.sv
`timescale 1ns/1ps
module cosfade_core
    import cosfade_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_in_l,
    input  logic signed [SMP_W-1:0] smp_in_r,
    input  logic                    ws_tick,
    input  logic                    cmd_we,
    input  logic                    cmd_sel,
    input  logic [CMD_W-1:0]        cmd_data,
    output logic                    smp_out_valid,
    output logic signed [SMP_W-1:0] smp_out_l,
    output logic signed [SMP_W-1:0] smp_out_r,
    output logic [FC_W-1:0]         fade_count
);
    fc_t     fc;
    coef_t   coef;
    sample_t ch_in  [CHANNELS];
    sample_t ch_out [CHANNELS];

    cosfade_ctrl u_ctrl (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .ws_tick(ws_tick),
        .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_data(cmd_data), .fc(fc)
    );

    cosfade_rom u_rom (.idx(fc), .coef(coef));

    assign ch_in[0] = smp_in_l;
    assign ch_in[1] = smp_in_r;

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        cosfade_scale u_scale (
            .clk(clk), .rst(rst), .en(smp_valid),
            .din(ch_in[ch]), .coef(coef), .dout(ch_out[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) smp_out_valid <= 1'b0;
        else     smp_out_valid <= smp_valid;
    end

    assign smp_out_l  = ch_out[0];
    assign smp_out_r  = ch_out[1];
    assign fade_count = fc;
endmodule

// File: rtl/cosfade_checker.sv
`timescale 1ns/1ps
module cosfade_checker
    import cosfade_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_valid,
    input logic signed [SMP_W-1:0] smp_in_l,
    input logic signed [SMP_W-1:0] smp_in_r,
    input logic                    cmd_we,
    input logic                    cmd_sel,
    input logic [CMD_W-1:0]        cmd_data,
    input logic                    smp_out_valid,
    input logic signed [SMP_W-1:0] smp_out_l,
    input logic signed [SMP_W-1:0] smp_out_r,
    input logic [FC_W-1:0]         fade_count
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (fade_count == '0 && !smp_out_valid && smp_out_l == '0 && smp_out_r == '0));

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> smp_out_valid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !smp_out_valid);

    a_r2_unity_passes: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && fade_count == '0) |=>
        (smp_out_l == $past(smp_in_l) && smp_out_r == $past(smp_in_r)));

    a_r2_mute_silent: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && fade_count == FC_W'(FC_MAX)) |=> (smp_out_l == '0 && smp_out_r == '0));

    a_r3_top_saturates: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_sel && cmd_data == 4'b0001 && fade_count == FC_W'(FC_MAX)) |=>
        (fade_count == FC_W'(FC_MAX)));

    a_r3_bottom_saturates: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_sel && cmd_data == 4'b0010 && fade_count == '0) |=> (fade_count == '0));

    // R8 and R9: a no-op command freezes the count for that cycle
    a_r8_noop_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_sel && (cmd_data == 4'b0000 || cmd_data == 4'b0011)) |=> $stable(fade_count));

    a_r7_rate_write_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !cmd_sel) |=> $stable(fade_count));

    a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (fade_count == $past(fade_count) ||
                         fade_count == $past(fade_count) + FC_W'(1) ||
                         fade_count + FC_W'(1) == $past(fade_count)));
endmodule

bind cosfade_core cosfade_checker u_chk (.*);

// File: tb/cosfade_core_test.sv
`timescale 1ns/1ps
module cosfade_core_test;
    logic               clk = 1'b0;
    logic               rst;
    logic               smp_valid;
    logic signed [17:0] smp_in_l, smp_in_r;
    logic               ws_tick, cmd_we, cmd_sel;
    logic [3:0]         cmd_data;
    logic               smp_out_valid;
    logic signed [17:0] smp_out_l, smp_out_r;
    logic [7:0]         fade_count;

    int checks = 0;
    int fails  = 0;

    int m_fc, m_tgt, m_rate, m_div;
    bit m_fast, m_active;
    bit exp_v;
    int exp_l, exp_r;

    always #2.5 clk = ~clk;

    cosfade_core uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_in_l(smp_in_l), .smp_in_r(smp_in_r),
        .ws_tick(ws_tick), .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
        .smp_out_valid(smp_out_valid), .smp_out_l(smp_out_l), .smp_out_r(smp_out_r),
        .fade_count(fade_count)
    );

    function automatic int coef_of(input int c);
        return $rtoi($cos(3.14159265358979 / 510.0 * c) * 65536.0 + 0.5);
    endfunction

    function automatic int scale_ref(input int s, input int c);
        longint p;
        p = longint'(s) * coef_of(c) + 32768;
        p = p >>> 16;
        if (p > 131071) p = 131071;
        if (p < -131072) p = -131072;
        return int'(p);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void step_model();
        if (m_fc < m_tgt) m_fc++;
        else if (m_fc > m_tgt) m_fc--;
    endfunction

    task automatic cyc(input bit v, input int l, input int r, input bit ws,
                       input bit we, input bit sel, input bit [3:0] d, input string tag);
        int prev;
        @(negedge clk);
        smp_valid = v; smp_in_l = 18'(l); smp_in_r = 18'(r);
        ws_tick = ws; cmd_we = we; cmd_sel = sel; cmd_data = d;
        exp_v = v;
        if (v) begin exp_l = scale_ref(l, m_fc); exp_r = scale_ref(r, m_fc); end
        prev = m_fc;
        if (we) begin
            if (!sel) m_rate = int'(d);
            else if (d[3:2] == 2'b00) begin
                if (d[1:0] == 2'b01) begin if (m_fc < 255) m_fc++; m_active = 0; end
                else if (d[1:0] == 2'b10) begin if (m_fc > 0) m_fc--; m_active = 0; end
            end else begin
                m_tgt = (d[3:2] == 2'b01) ? 0 : (d[3:2] == 2'b10) ? 255 : 214;
                m_fast = d[0]; m_active = 1; m_div = 0;
            end
        end else if (m_active) begin
            if (m_fast) begin
                if (v) step_model();
            end else if (ws) begin
                if (m_div >= m_rate) begin m_div = 0; step_model(); end
                else m_div++;
            end
        end
        @(posedge clk); #1;
        chk(int'(fade_count) == m_fc, {tag, " count"}, int'(fade_count), m_fc);
        chk(smp_out_valid == exp_v, "R2 valid", int'(smp_out_valid), int'(exp_v));
        if (exp_v) begin
            chk(int'(smp_out_l) == exp_l, {"R2 left ", tag}, int'(smp_out_l), exp_l);
            chk(int'(smp_out_r) == exp_r, {"R2 right ", tag}, int'(smp_out_r), exp_r);
        end
        chk(int'(fade_count) - prev <= 1 && prev - int'(fade_count) <= 1, "R10 step size",
            int'(fade_count), prev);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 4'h0, tag);
    endtask
    task automatic sample(input int l, input int r, input string tag);
        cyc(1, l, r, 0, 0, 0, 4'h0, tag);
    endtask
    task automatic tick(input string tag);
        cyc(0, 0, 0, 1, 0, 0, 4'h0, tag);
    endtask
    task automatic fcmd(input bit [3:0] d, input string tag);
        cyc(0, 0, 0, 0, 1, 1, d, tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        rst = 1; smp_valid = 0; smp_in_l = 0; smp_in_r = 0;
        ws_tick = 0; cmd_we = 0; cmd_sel = 0; cmd_data = 0;
        m_fc = 0; m_tgt = 0; m_rate = 0; m_div = 0; m_fast = 0; m_active = 0;
        exp_v = 0; exp_l = 0; exp_r = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(fade_count == 0, "R1 reset count", int'(fade_count), 0);
        chk(!smp_out_valid, "R1 reset valid", int'(smp_out_valid), 0);
        chk(smp_out_l == 0 && smp_out_r == 0, "R1 reset outputs", int'(smp_out_l), 0);
        @(negedge clk); rst = 0;
        idle("R1");

        // R2: unity gain at the extremes of the sample range
        sample(131071, -131072, "R2 unity");
        sample(-1, 1, "R2 unity small");

        // R3: single steps and saturation at 0
        repeat (3) fcmd(4'b0001, "R3 step down");
        chk(fade_count == 3, "R3 after three step-downs", int'(fade_count), 3);
        sample(100000, -70000, "R2 at count 3");
        repeat (4) fcmd(4'b0010, "R3 step up");
        chk(fade_count == 0, "R3 saturate at 0", int'(fade_count), 0);

        // R7, R6: slow ramp toward -12 dB with rate 2
        cyc(0, 0, 0, 0, 1, 0, 4'd2, "R7 rate write");
        fcmd(4'b1100, "R4 -12dB slow");
        tick("R6 tick1"); tick("R6 tick2");
        chk(fade_count == 0, "R6 no step before rate+1 ticks", int'(fade_count), 0);
        tick("R6 tick3");
        chk(fade_count == 1, "R6 step on third tick", int'(fade_count), 1);
        repeat (3) sample(5000, -5000, "R6 samples ignored in slow");
        chk(fade_count == 1, "R6 samples do not step", int'(fade_count), 1);

        // R4: bit 1 ignored, full scale fast from 6
        repeat (5) fcmd(4'b0001, "R3 step down");
        fcmd(4'b0111, "R4 full scale fast, bit1 set");
        repeat (3) sample(1234, 4321, "R5 fast ramp");
        chk(fade_count == 3, "R4 fast full scale ramp", int'(fade_count), 3);
        repeat (4) tick("R5 ticks ignored in fast");
        chk(fade_count == 3, "R5 ticks ignored", int'(fade_count), 3);
        repeat (4) sample(-9999, 9999, "R5 reach target");
        chk(fade_count == 0, "R5 stop at target 0", int'(fade_count), 0);

        // R5: mute fast to 255, then R3 saturation at the top
        fcmd(4'b1001, "R4 mute fast");
        for (int i = 0; i < 256; i++) sample(i * 500 - 60000, 131071 - i * 300, "R5 mute ramp");
        chk(fade_count == 255, "R5 mute reaches 255", int'(fade_count), 255);
        sample(50000, -50000, "R2 mute output");
        chk(smp_out_l == 0 && smp_out_r == 0, "R2 muted output zero", int'(smp_out_l), 0);
        fcmd(4'b0001, "R3 step down at top");
        chk(fade_count == 255, "R3 saturate at 255", int'(fade_count), 255);

        // R8, R9: no-op commands during an active slow ramp
        cyc(0, 0, 0, 0, 1, 0, 4'd0, "R7 rate zero");
        fcmd(4'b0100, "R4 full scale slow");
        tick("R6 rate zero tick");
        chk(fade_count == 254, "R6 one step per tick at rate 0", int'(fade_count), 254);
        cyc(0, 0, 0, 1, 1, 1, 4'b0000, "R8 noop with tick");
        chk(fade_count == 254, "R9 command beats tick", int'(fade_count), 254);
        cyc(0, 0, 0, 1, 1, 1, 4'b0011, "R8 code 0011");
        chk(fade_count == 254, "R8 code 0011 no action", int'(fade_count), 254);
        tick("R8 ramp still active");
        chk(fade_count == 253, "R8 ramp continues", int'(fade_count), 253);

        // R9: rate write collides with a fast step
        fcmd(4'b1101, "R4 -12dB fast");
        cyc(1, 777, -777, 0, 1, 0, 4'd5, "R9 rate write with sample");
        chk(fade_count == 253, "R9 write suppresses fast step", int'(fade_count), 253);
        sample(777, -777, "R5 fast step");
        chk(fade_count == 252, "R5 step after collision", int'(fade_count), 252);

        // random mix
        void'($urandom(32'd4242));
        for (int i = 0; i < 6000; i++) begin
            bit v, ws, we, sel;
            int l, r;
            v   = ($urandom % 2) == 0;
            ws  = ($urandom % 4) == 0;
            we  = ($urandom % 24) == 0;
            sel = ($urandom % 4) != 0;
            l   = int'($urandom % 262144) - 131072;
            r   = int'($urandom % 262144) - 131072;
            cyc(v, l, r, ws, we, sel, 4'($urandom % 16), "R5 R6 random");
        end
        summary();
    end
endmodule